// File: doc/BRIEF.md
# Low-Power Ratio and Voltage Sequencer

This block moves a multi-core processor into and out of an extended halt state. It watches one halt flag per core, a configuration enable and a break-event input. When every core is halted and the feature is enabled, it saves the current core clock ratio and voltage ID. It then lowers the ratio first and the voltage ID second. A break event brings the core back: the saved voltage ID is restored first and the saved ratio after it.

Each change is a request level that stays up until its own settle acknowledge arrives. The bus clock select output is fixed and never changes. Snoop requests are acknowledged in every state, including the low-power one.

Top module: `lpseq_sequencer`

## Requirements
- R1: When idle and all `NCORES` halt flags are 1, `xhalt_en_i` is 1 and `break_i` is 0, the block leaves idle on the next clock edge. On that same edge it captures `cur_ratio_i` and `cur_vid_i` as the saved values.
- R2: If any core is not halted, or `xhalt_en_i` is 0, the block stays idle. `busy_o`, `ratio_req_o` and `vid_req_o` all stay 0.
- R3: On entry, `ratio_req_o` is raised first with `ratio_val_o` = `LOW_RATIO`. `vid_req_o` is raised with `vid_val_o` = `LOW_VID` only after `ratio_ack_i`. The two requests are never high together.
- R4: A break in the low state raises `vid_req_o` with the saved VID. Only after `vid_ack_i` is `ratio_req_o` raised with the saved ratio.
- R5: Each request stays high until its matching acknowledge arrives. An acknowledge with no matching request has no effect.
- R6: A break during entry is remembered and the current step still completes. If the break came during the ratio step, the VID step is skipped and the saved ratio is restored. If it came during the VID step, the full exit runs.
- R7: `in_xhalt_o` is 1 only in the low state, from the entry VID acknowledge until a break.
- R8: `busy_o` is 1 from the first entry step until the final exit ratio acknowledge.
- R9: `snoop_ack_o` equals `snoop_req_i` delayed by one clock, in every state.
- R10: `bus_sel_o` always equals `BUS_SEL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| core_halted_i | input | NCORES | Per-core halt flag |
| xhalt_en_i | input | 1 | Extended halt enable |
| break_i | input | 1 | Break event |
| cur_ratio_i | input | RW | Current core ratio |
| cur_vid_i | input | VW | Current voltage ID |
| ratio_ack_i | input | 1 | Ratio settle acknowledge |
| vid_ack_i | input | 1 | VID settle acknowledge |
| snoop_req_i | input | 1 | Snoop request |
| ratio_req_o | output | 1 | Ratio change request |
| ratio_val_o | output | RW | Requested ratio |
| vid_req_o | output | 1 | VID change request |
| vid_val_o | output | VW | Requested VID |
| busy_o | output | 1 | Sequence in progress |
| in_xhalt_o | output | 1 | In extended halt |
| snoop_ack_o | output | 1 | Snoop acknowledge |
| bus_sel_o | output | 2 | Bus clock select (fixed) |

## Verification
A table of halt masks crossed with the enable and break inputs checks the entry gate. Only the all-halted, enabled, no-break row may start a sequence; partial masks and a disabled enable must leave the block idle. Full runs check the order of the ratio and VID requests and the values on them, with the current-value inputs changed mid-run so that restoration has to come from the saved values. Breaks placed in the ratio step and in the VID step tell the shortened exit apart from the full exit. Stray acknowledges and snoops in the low state cover the remaining rules.

// File: rtl/lpseq_pkg.sv
package lpseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ENT_RATIO, ST_ENT_VID, ST_LOW, ST_EXI_VID, ST_EXI_RATIO
  } lpseq_state_e;
endpackage

// File: rtl/lpseq_entry_gate.sv
module lpseq_entry_gate #(
  parameter int NCORES = 4
) (
  input  logic [NCORES-1:0] core_halted_i,
  input  logic              xhalt_en_i,
  input  logic              break_i,
  output logic              enter_o
);
  logic [NCORES:0] chain;
  assign chain[0] = 1'b1;
  for (genvar g = 0; g < NCORES; g++) begin : g_and
    assign chain[g+1] = chain[g] & core_halted_i[g];
  end
  assign enter_o = chain[NCORES] & xhalt_en_i & ~break_i;

  always_comb begin
    if (enter_o) a_gate_r1 : assert (&core_halted_i);
  end
endmodule

// File: rtl/lpseq_level_store.sv
module lpseq_level_store #(
  parameter int RW = 6,
  parameter int VW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [RW-1:0] ratio_i,
  input  logic [VW-1:0] vid_i,
  output logic [RW-1:0] ratio_o,
  output logic [VW-1:0] vid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_o <= '0;
      vid_o   <= '0;
    end else if (cap_i) begin
      ratio_o <= ratio_i;
      vid_o   <= vid_i;
    end
  end

  p_hold_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(ratio_o) && $stable(vid_o));
endmodule

// File: rtl/lpseq_sequencer.sv
module lpseq_sequencer
  import lpseq_pkg::*;
#(
  parameter int           NCORES    = 4,
  parameter int           RW        = 6,
  parameter int           VW        = 7,
  parameter logic [RW-1:0] LOW_RATIO = 6'd6,
  parameter logic [VW-1:0] LOW_VID   = 7'h20,
  parameter logic [1:0]   BUS_SEL   = 2'd1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCORES-1:0] core_halted_i,
  input  logic              xhalt_en_i,
  input  logic              break_i,
  input  logic [RW-1:0]     cur_ratio_i,
  input  logic [VW-1:0]     cur_vid_i,
  input  logic              ratio_ack_i,
  input  logic              vid_ack_i,
  input  logic              snoop_req_i,
  output logic              ratio_req_o,
  output logic [RW-1:0]     ratio_val_o,
  output logic              vid_req_o,
  output logic [VW-1:0]     vid_val_o,
  output logic              busy_o,
  output logic              in_xhalt_o,
  output logic              snoop_ack_o,
  output logic [1:0]        bus_sel_o
);
  lpseq_state_e state_q, state_d;
  logic          enter;
  logic          brk_pend_q;
  logic [RW-1:0] sv_ratio;
  logic [VW-1:0] sv_vid;
  logic          cap;

  lpseq_entry_gate #(.NCORES(NCORES)) u_gate (
    .core_halted_i(core_halted_i), .xhalt_en_i(xhalt_en_i),
    .break_i(break_i), .enter_o(enter)
  );

  assign cap = (state_q == ST_IDLE) && enter;

  lpseq_level_store #(.RW(RW), .VW(VW)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap),
    .ratio_i(cur_ratio_i), .vid_i(cur_vid_i),
    .ratio_o(sv_ratio), .vid_o(sv_vid)
  );

  // break seen during entry, including the acking cycle
  logic brk_seen;
  assign brk_seen = brk_pend_q | break_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (enter) state_d = ST_ENT_RATIO;
      ST_ENT_RATIO: if (ratio_ack_i) state_d = brk_seen ? ST_EXI_RATIO : ST_ENT_VID;
      ST_ENT_VID:   if (vid_ack_i) state_d = brk_seen ? ST_EXI_VID : ST_LOW;
      ST_LOW:       if (break_i) state_d = ST_EXI_VID;
      ST_EXI_VID:   if (vid_ack_i) state_d = ST_EXI_RATIO;
      ST_EXI_RATIO: if (ratio_ack_i) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      brk_pend_q  <= 1'b0;
      snoop_ack_o <= 1'b0;
    end else begin
      state_q     <= state_d;
      snoop_ack_o <= snoop_req_i;
      if (state_q == ST_ENT_RATIO || state_q == ST_ENT_VID)
        brk_pend_q <= brk_seen;
      else
        brk_pend_q <= 1'b0;
    end
  end

  assign ratio_req_o = (state_q == ST_ENT_RATIO) || (state_q == ST_EXI_RATIO);
  assign vid_req_o   = (state_q == ST_ENT_VID)   || (state_q == ST_EXI_VID);
  assign ratio_val_o = (state_q == ST_EXI_RATIO) ? sv_ratio : LOW_RATIO;
  assign vid_val_o   = (state_q == ST_EXI_VID)   ? sv_vid   : LOW_VID;
  assign busy_o      = (state_q != ST_IDLE);
  assign in_xhalt_o  = (state_q == ST_LOW);
  assign bus_sel_o   = BUS_SEL;

  p_gate_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(&core_halted_i && xhalt_en_i));
  p_req_excl_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ratio_req_o && vid_req_o));
  p_vid_after_ratio_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vid_req_o) && !$past(in_xhalt_o) |-> $past(ratio_req_o && ratio_ack_i));
  p_exit_order_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_xhalt_o && break_i |=> vid_req_o && !ratio_req_o);
  p_req_hold_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_req_o && !ratio_ack_i |=> ratio_req_o);
  p_busy_hold_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !(ratio_req_o && ratio_ack_i) |=> busy_o);
  p_snoop_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_req_i |=> snoop_ack_o);
endmodule

// File: tb/sim_lpseq_sequencer.sv
module sim_lpseq_sequencer;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [3:0] halted = '0;
  logic en = 0, brk = 0, rack = 0, vack = 0, sreq = 0;
  logic [5:0] cr = 6'd20;
  logic [6:0] cv = 7'h50;
  logic rreq, vreq, busy, inx, sack;
  logic [5:0] rval;
  logic [6:0] vval;
  logic [1:0] bsel;
  int n_run = 0, n_fail = 0;

  lpseq_sequencer u0 (
    .clk_i(clk), .rst_ni(rst_n), .core_halted_i(halted), .xhalt_en_i(en),
    .break_i(brk), .cur_ratio_i(cr), .cur_vid_i(cv), .ratio_ack_i(rack),
    .vid_ack_i(vack), .snoop_req_i(sreq), .ratio_req_o(rreq),
    .ratio_val_o(rval), .vid_req_o(vreq), .vid_val_o(vval), .busy_o(busy),
    .in_xhalt_o(inx), .snoop_ack_o(sack), .bus_sel_o(bsel)
  );

  task automatic step(); @(posedge clk); #1; endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  // {halted[3:0], en, brk, expect_enter}
  localparam logic [6:0] VEC [8] = '{
    7'b1111_1_0_1, 7'b1110_1_0_0, 7'b0111_1_0_0, 7'b0000_1_0_0,
    7'b1111_0_0_0, 7'b1111_1_1_0, 7'b1011_1_0_0, 7'b1111_1_0_1
  };

  task automatic pulse_r(); rack = 1; step(); rack = 0; endtask
  task automatic pulse_v(); vack = 1; step(); vack = 0; endtask
  task automatic pulse_b(); brk = 1; step(); brk = 0; endtask

  task automatic drain();
    halted = '0;
    pulse_r(); pulse_v(); pulse_b(); pulse_v(); pulse_r();
  endtask

  initial begin
    #(5ns * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(); step();
    chk_eq("R8 reset busy", busy, 0);
    chk_eq("R3 reset rreq", rreq, 0);
    rst_n = 1; step();
    chk_eq("R10 bus_sel", bsel, 1);

    foreach (VEC[i]) begin
      halted = VEC[i][6:3]; en = VEC[i][2]; brk = VEC[i][1];
      step();
      halted = '0; brk = 0;
      chk_eq($sformatf("R1/R2 vec%0d busy", i), busy, VEC[i][0]);
      chk_eq($sformatf("R2 vec%0d vreq", i), vreq, 0);
      if (VEC[i][0]) drain();
      step();
      chk_eq($sformatf("R8 vec%0d idle", i), busy, 0);
    end

    // R5 stray acks in idle
    rack = 1; vack = 1; step(); rack = 0; vack = 0;
    chk_eq("R5 stray ack idle", busy, 0);

    // full run, R1 R3 R4 R5 R7 R8 R9 R10
    cr = 6'd20; cv = 7'h50; halted = 4'hF; en = 1; step();
    halted = '0; cr = 6'd3; cv = 7'h11;
    chk_eq("R3 first ratio req", rreq, 1);
    chk_eq("R3 low ratio", rval, 6);
    chk_eq("R3 no vid yet", vreq, 0);
    vack = 1; step(); vack = 0;
    chk_eq("R5 ratio req held", rreq, 1);
    chk_eq("R5 vid ack ignored", vreq, 0);
    pulse_r();
    chk_eq("R3 vid req", vreq, 1);
    chk_eq("R3 low vid", vval, 'h20);
    chk_eq("R3 ratio dropped", rreq, 0);
    pulse_v();
    chk_eq("R7 in xhalt", inx, 1);
    chk_eq("R8 busy low state", busy, 1);
    sreq = 1; step(); sreq = 0;
    chk_eq("R9 snoop ack", sack, 1);
    chk_eq("R10 bus_sel low", bsel, 1);
    step();
    chk_eq("R9 snoop ack drop", sack, 0);
    pulse_b();
    chk_eq("R4 vid first", vreq, 1);
    chk_eq("R4 saved vid", vval, 'h50);
    chk_eq("R4 ratio waits", rreq, 0);
    chk_eq("R7 left xhalt", inx, 0);
    pulse_v();
    chk_eq("R4 ratio req", rreq, 1);
    chk_eq("R4 saved ratio", rval, 20);
    chk_eq("R8 busy before last ack", busy, 1);
    pulse_r();
    chk_eq("R8 busy cleared", busy, 0);

    // R6 break during ratio step
    cr = 6'd25; cv = 7'h44; halted = 4'hF; step(); halted = '0;
    pulse_b();
    chk_eq("R6 step continues", rreq, 1);
    chk_eq("R6 ratio low", rval, 6);
    pulse_r();
    chk_eq("R6 vid skipped", vreq, 0);
    chk_eq("R6 restore ratio", rreq, 1);
    chk_eq("R6 saved ratio", rval, 25);
    pulse_r();
    chk_eq("R6 idle", busy, 0);

    // R6 break during vid step
    halted = 4'hF; step(); halted = '0;
    pulse_r();
    pulse_b();
    chk_eq("R6 vid step continues", vreq, 1);
    pulse_v();
    chk_eq("R6 full exit vid", vreq, 1);
    chk_eq("R6 saved vid", vval, 'h44);
    chk_eq("R7 never low", inx, 0);
    pulse_v(); pulse_r();
    chk_eq("R6 idle2", busy, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule